// File: doc/BRIEF.md
# Paged Serial Configuration Readout

This block is the read side of a bit-serial memory that loads an FPGA's configuration. It holds a one-bit-wide array of `2**ADDR_W` bits. The full-size part corresponds to `ADDR_W = 24`, which is 16,777,216 bits. An address counter walks through the array and presents one bit at a time on a data output that can be tri-stated. The counter advances on every rising edge of the configuration clock while the device is selected. The bit at the current address is visible as soon as the output is enabled, so the loading FPGA sees the first bit before it sends its first clock edge.

The address space can optionally be split into four equal pages, so one device can hold four separate bitstreams. A page-enable input turns this on and a two-bit page index picks the page. Both are captured only while the reset/output-enable input is low. When the last bit of the active region has gone out, the block raises a cascade flag and floats its data output, so a following device can continue the stream.

The block has three other operating conditions. Chip select high gives standby. Serial-enable low gives programming mode. Reset/output-enable low resets the counter. In all three the data output floats. A simple synchronous write port fills the array for test.

Top module: `paged_cfg_reader`

## Requirements
- R1: While `oe_rst_i` is low, `data_oe_o` and `data_o` are 0. At the next rising edge the counter returns to the first address of the selected region, so when the output is enabled again it shows that first bit.
- R2: While `cs_n_i` is high, `data_oe_o` is 0 and the counter holds. This includes standby, where `ser_en_i` is high. Once `cs_n_i` falls, the bit that was pending is shown again.
- R3: While `ser_en_i` is low (programming mode), readout is disabled: `data_oe_o` is 0 and the counter does not move.
- R4: The output is enabled when `oe_rst_i` = 1, `cs_n_i` = 0, `ser_en_i` = 1 and the region is not exhausted. In that state `data_o` shows the current bit before any clock edge, and each rising edge moves to the next higher address.
- R5: With page mode off, the region is the whole array, addresses 0 to 2**ADDR_W-1, and `page_sel_i` has no effect.
- R6: With page mode on, `page_sel_i` (binary 0 to 3) selects the region from `page_sel_i`×2**(ADDR_W-2) to that value plus 2**(ADDR_W-2)-1. The counter never leaves that region.
- R7: `page_en_i` and `page_sel_i` are sampled only on edges where `oe_rst_i` is low. Changes made during a readout have no effect on the bits that follow.
- R8: At the rising edge after the last bit of the region, `casc_o` goes to 1 and `data_oe_o` goes to 0. Both stay that way until `oe_rst_i` is low at a rising edge.
- R9: When `wr_en_i` is 1 at a rising edge, `wr_bit_i` is stored at `wr_addr_i`. No other bit changes.
- R10: An asynchronous low on `rst_n` sets the address to 0, selects whole-array mode and clears `casc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; also clocks the write port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| oe_rst_i | input | 1 | Low: reset the counter and float the output; high: allow output |
| cs_n_i | input | 1 | Active-low chip select |
| ser_en_i | input | 1 | Low selects programming mode, which disables readout |
| page_en_i | input | 1 | Enables the four-page split of the address space |
| page_sel_i | input | 2 | Page index, used while page mode is on |
| wr_en_i | input | 1 | Test write strobe |
| wr_addr_i | input | ADDR_W | Test write bit address |
| wr_bit_i | input | 1 | Test write data |
| data_o | output | 1 | Serial configuration bit; 0 while not driven |
| data_oe_o | output | 1 | Drive enable for the data pin; 0 means high-impedance |
| casc_o | output | 1 | Region exhausted; the next device takes over |

## Verification
Several properties are checked on every clock cycle. The counter always stays inside the region that was latched. It steps by exactly one on each enabled edge and freezes whenever it is deselected, in standby or in programming mode. The latched page settings do not change outside the counter reset. The cascade flag is sticky, and the driver is off whenever that flag or any disabling control is active. Some behaviour can only be shown by the bench's scenarios, because it depends on the array contents. This covers the order of the bits read out, the isolation between pages, the resumption at the exact pending bit after a pause, the restart at the region's first bit after a reset pulse, and the write port.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int unsigned PAGE_SEL_W = 2;
  localparam int unsigned PAGE_COUNT = 1 << PAGE_SEL_W;

  // Page configuration captured while the counter is held in reset.
  typedef struct packed {
    logic                  paged;
    logic [PAGE_SEL_W-1:0] idx;
  } page_cfg_t;
endpackage

// File: rtl/cfgrd_bitmem.sv
module cfgrd_bitmem #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic cells [DEPTH];

  // Storage array: written synchronously, read asynchronously.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[wr_addr] <= wr_bit;
    end
  end

  assign rd_bit = cells[rd_addr];
endmodule

// File: rtl/cfgrd_addr_ctr.sv
module cfgrd_addr_ctr
  import cfgrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,     // counter reset request (oe_rst low)
  input  logic              adv,      // device selected and reading
  input  page_cfg_t         cfg_in,
  output logic [ADDR_W-1:0] ptr,
  output logic              done
);
  localparam int unsigned PW = ADDR_W - PAGE_SEL_W;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              done_q, done_d;
  page_cfg_t         cfg_q, cfg_d;
  logic [ADDR_W-1:0] first_live, first_q, last_q;
  logic              upd;

  // Region bounds: the start comes from the live inputs, the end from the latched copy.
  assign first_live = cfg_in.paged ? {cfg_in.idx, {PW{1'b0}}} : '0;
  assign first_q    = cfg_q.paged  ? {cfg_q.idx,  {PW{1'b0}}} : '0;
  assign last_q     = cfg_q.paged  ? {cfg_q.idx,  {PW{1'b1}}} : '1;

  assign upd = load | (adv & ~done_q);

  always_comb begin
    ptr_d  = ptr_q;
    done_d = done_q;
    cfg_d  = cfg_q;
    if (load) begin
      ptr_d  = first_live;
      done_d = 1'b0;
      cfg_d  = cfg_in;
    end else if (adv && !done_q) begin
      if (ptr_q == last_q) begin
        done_d = 1'b1;
      end else begin
        ptr_d = ptr_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      done_q <= 1'b0;
      cfg_q  <= '0;
    end else if (upd) begin
      ptr_q  <= ptr_d;
      done_q <= done_d;
      cfg_q  <= cfg_d;
    end
  end

  assign ptr  = ptr_q;
  assign done = done_q;

  // R6: the counter stays inside the latched region.
  p_in_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q >= first_q) && (ptr_q <= last_q));

  // R4: each enabled edge below the region end advances by one.
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && !done_q && ptr_q != last_q) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

  // R2 / R3: the counter freezes while deselected, in standby or in programming mode.
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> ($stable(ptr_q) && $stable(done_q)));

  // R7: the page settings change only during a counter reset.
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  // R8: exhaustion is sticky until the next reset pulse.
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done_q) |=> done_q);
endmodule

// File: rtl/cfgrd_out_ctl.sv
module cfgrd_out_ctl (
  input  logic oe_rst,
  input  logic cs_n,
  input  logic ser_en,
  input  logic done,
  input  logic mem_bit,
  output logic adv,
  output logic data,
  output logic data_oe,
  output logic casc
);
  logic selected;

  // Reading is possible only outside programming mode, with chip select low and reset released.
  assign selected = oe_rst & ~cs_n & ser_en;
  assign adv      = selected;
  assign data_oe  = selected & ~done;
  assign data     = data_oe & mem_bit;
  assign casc     = done;
endmodule

// File: rtl/paged_cfg_reader.sv
module paged_cfg_reader
  import cfgrd_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_rst_i,
  input  logic              cs_n_i,
  input  logic              ser_en_i,
  input  logic              page_en_i,
  input  logic [1:0]        page_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              casc_o
);
  logic [ADDR_W-1:0] ptr;
  logic              done;
  logic              adv;
  logic              mem_bit;
  page_cfg_t         cfg_in;

  assign cfg_in.paged = page_en_i;
  assign cfg_in.idx   = page_sel_i;

  cfgrd_bitmem #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_bit  (wr_bit_i),
    .rd_addr (ptr),
    .rd_bit  (mem_bit)
  );

  cfgrd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (~oe_rst_i),
    .adv    (adv),
    .cfg_in (cfg_in),
    .ptr    (ptr),
    .done   (done)
  );

  cfgrd_out_ctl u_out (
    .oe_rst  (oe_rst_i),
    .cs_n    (cs_n_i),
    .ser_en  (ser_en_i),
    .done    (done),
    .mem_bit (mem_bit),
    .adv     (adv),
    .data    (data_o),
    .data_oe (data_oe_o),
    .casc    (casc_o)
  );

  // R8: the driver is off once the handoff has happened.
  p_casc_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    casc_o |-> !data_oe_o);

  // R1: the output floats while the counter is held in reset.
  p_reset_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_rst_i |-> (!data_oe_o && !data_o));

  // R3: programming mode never drives the data pin.
  p_prog_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en_i |-> !data_oe_o);

  // R2: a deselected device never drives the data pin.
  p_cs_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> !data_oe_o);
endmodule

// File: tb/paged_cfg_reader_bench.sv
module paged_cfg_reader_bench;
  localparam int unsigned AW    = 6;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PD    = DEPTH / 4;

  // Each vector is {page_en, page_sel[1:0]}.
  localparam logic [2:0] VEC [6] = '{3'b100, 3'b101, 3'b110, 3'b111, 3'b000, 3'b011};

  logic          clk = 1'b0;
  logic          rst_n, oe_rst, cs_n, ser_en, page_en, wr_en, wr_bit;
  logic [1:0]    page_sel;
  logic [AW-1:0] wr_addr;
  logic          data_o, data_oe_o, casc_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;
  logic ref_mem [DEPTH];

  always #10 clk = ~clk;

  paged_cfg_reader #(.ADDR_W(AW)) u_paged_cfg_reader (
    .clk(clk), .rst_n(rst_n), .oe_rst_i(oe_rst), .cs_n_i(cs_n), .ser_en_i(ser_en),
    .page_en_i(page_en), .page_sel_i(page_sel), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_bit_i(wr_bit), .data_o(data_o), .data_oe_o(data_oe_o), .casc_o(casc_o)
  );

  function automatic logic pat(input int i);
    logic [7:0] v;
    v = 8'(i * 29 + 11);
    return v[3] ^ v[0] ^ v[5];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Pulse the counter reset with the given page setting, then enable readout.
  task automatic start_region(input logic pe, input logic [1:0] sel);
    @(negedge clk);
    page_en = pe; page_sel = sel; oe_rst = 1'b0; cs_n = 1'b1; ser_en = 1'b1;
    @(negedge clk);
    oe_rst = 1'b1; cs_n = 1'b0;
  endtask

  task automatic expect_bits(input int from, input int upto, input string req);
    for (int k = from; k <= upto; k++) begin
      #1;
      chk(data_oe_o && (data_o == ref_mem[k]), req, int'({data_oe_o, data_o}), int'({1'b1, ref_mem[k]}));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; oe_rst = 1'b0; cs_n = 1'b1; ser_en = 1'b1; page_en = 1'b0;
    page_sel = 2'd0; wr_en = 1'b0; wr_bit = 1'b0; wr_addr = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    #1;
    chk(!data_oe_o && !data_o, "R10 reset float", int'(data_oe_o), 0);
    chk(!casc_o, "R10 reset casc", int'(casc_o), 0);
    rst_n = 1'b1; oe_rst = 1'b1;

    // R9: fill the array through the write port while deselected.
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i); wr_bit = ref_mem[i];
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R10: after reset alone the whole array starts at address 0.
    cs_n = 1'b0;
    #1;
    chk(data_oe_o && data_o == ref_mem[0], "R10 start addr", int'(data_o), int'(ref_mem[0]));

    // Vector walk: R5 / R6 bit order per region and cascade at the end.
    for (int v = 0; v < 6; v++) begin
      int base;
      int len;
      base = VEC[v][2] ? int'(VEC[v][1:0]) * PD : 0;
      len  = VEC[v][2] ? PD : DEPTH;
      start_region(VEC[v][2], VEC[v][1:0]);
      expect_bits(base, base + len - 1, VEC[v][2] ? "R6 page bits" : "R5 full bits");
      #1;
      chk(casc_o && !data_oe_o, "R8 casc at end", int'({casc_o, data_oe_o}), 2);
    end

    // R8: sticky until the reset pulse.
    repeat (5) @(negedge clk);
    #1;
    chk(casc_o && !data_oe_o, "R8 casc sticky", int'({casc_o, data_oe_o}), 2);
    oe_rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!casc_o, "R8 casc cleared", int'(casc_o), 0);

    // R1: a reset pulse in the middle of a readout restarts the region.
    start_region(1'b1, 2'd2);
    repeat (5) @(negedge clk);
    oe_rst = 1'b0;
    #1;
    chk(!data_oe_o && !data_o, "R1 float in reset", int'(data_oe_o), 0);
    @(negedge clk);
    oe_rst = 1'b1;
    #1;
    chk(data_oe_o && data_o == ref_mem[2*PD], "R1 restart bit", int'(data_o), int'(ref_mem[2*PD]));
    repeat (3) @(negedge clk);

    // R2: chip select high (standby) floats and holds at bit 2*PD+3.
    cs_n = 1'b1;
    #1;
    chk(!data_oe_o, "R2 standby float", int'(data_oe_o), 0);
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    #1;
    chk(data_oe_o && data_o == ref_mem[2*PD+3], "R2 resume bit", int'(data_o), int'(ref_mem[2*PD+3]));

    // R3: programming mode floats and holds.
    ser_en = 1'b0;
    #1;
    chk(!data_oe_o, "R3 prog float", int'(data_oe_o), 0);
    repeat (3) @(negedge clk);
    ser_en = 1'b1;
    #1;
    chk(data_oe_o && data_o == ref_mem[2*PD+3], "R3 resume bit", int'(data_o), int'(ref_mem[2*PD+3]));

    // R7: page inputs changed mid-readout are ignored; the page still ends on time.
    @(negedge clk);
    page_en = 1'b0; page_sel = 2'd0;
    expect_bits(2*PD + 4, 3*PD - 1, "R7 page held");
    #1;
    chk(casc_o && !data_oe_o, "R7 end of held page", int'({casc_o, data_oe_o}), 2);

    // R9: overwrite one bit and check that its neighbour is untouched.
    @(negedge clk);
    cs_n = 1'b1;
    wr_en = 1'b1; wr_addr = AW'(PD); wr_bit = ~ref_mem[PD];
    @(negedge clk);
    wr_en = 1'b0;
    ref_mem[PD] = ~ref_mem[PD];
    start_region(1'b1, 2'd1);
    #1;
    chk(data_oe_o && data_o == ref_mem[PD], "R9 written bit", int'(data_o), int'(ref_mem[PD]));
    @(negedge clk);
    #1;
    chk(data_oe_o && data_o == ref_mem[PD+1], "R9 neighbour bit", int'(data_o), int'(ref_mem[PD+1]));

    ended = 1'b1;
    finish_run();
  end
endmodule